// File: doc/BRIEF.md
# Pass-Code Gated I2C Register Port

This block is an I2C target that gives a bus master byte-wide access to a bank of 128 registers held outside the block. After reset the bank is locked. The target does not answer its register address, and nothing reaches the bank. The master opens the port by sending a fixed two-byte key as a block write to a second, separate target address. Once the port is open, it stays open until the next reset.

Every register transfer starts with a pointer byte. Bit 7 of the pointer byte picks the mode: 1 means block, 0 means single. Bits 6:0 give the register address. In block mode, each byte written or read moves the address up by one, and the address wraps from 0x7F to 0x00. A single read works in two steps. The master first does a write that carries only the pointer. It then does a read, either after a repeated Start or in a new transfer.

The bus pins are sampled through two-flop synchronizers. The target drives SDA only by pulling it low (`sda_oe`). The bank is reached through a parallel port. The address and write data come out combinationally from internal state, and the read data is expected back in the same cycle.

Top module: `i2c_gated_regport`

## Requirements
- R1: After reset `sda_oe` and `reg_we` are low, and the port is locked.
- R2: While locked, the register target address (7-bit 0x10, wire bytes 0x20 write / 0x21 read) gets no acknowledge (SDA stays high in the 9th clock) and `reg_we` never pulses.
- R3: The transfer Start, 0x22, 0x81, 0xF4, 0x4F, Stop unlocks the port. Each of those bytes is acknowledged. Afterwards, address 0x20/0x21 is acknowledged, and the port stays unlocked until reset.
- R4: Any of the following leaves the port locked: a wrong pointer byte, a wrong key byte, fewer or more than two key bytes, a Stop before the key is complete, or a repeated Start in the middle of the key.
- R5: Addresses other than 0x10 (any R/W) and 0x11 (write only) get no acknowledge.
- R6: A write whose pointer has bit 7 = 0 stores only the first data byte, at address pointer[6:0]. Any later data bytes are acknowledged but not stored.
- R7: A single read (a pointer-only write followed by a read of one byte) returns the register at the pointer address.
- R8: A block write (pointer bit 7 = 1) stores consecutive bytes at consecutive addresses, wrapping from 0x7F to 0x00.
- R9: A block read returns bytes from consecutive addresses, wrapping from 0x7F to 0x00, for as long as the master acknowledges.
- R10: After the master NACKs a read byte, the target leaves SDA released until the next Start.
- R11: `sda_oe` changes only while the synchronized SCL is low. The target acknowledges each accepted byte by pulling SDA low for the 9th clock.
- R12: A Start or repeated Start at any point, including the middle of a byte, returns the target to the address phase without writing the partial byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | 7 | Current register address |
| reg_wdata | output | 8 | Write data for the bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Bank data at `reg_addr`, same cycle |

## Verification
The hardest cases to reach are the unlock paths that almost succeed: a key that is correct up to its last byte and is then cut short, over-run, or interrupted by a repeated Start. Only a later probe of the register address can reveal the lock state. The bench therefore follows each failed attempt with an address probe and checks for a NACK. It also aborts a data byte after three bits with a repeated Start, and it clocks extra bytes after a master NACK, to show that no write happens and that SDA stays released.

// File: rtl/i2c_gated_regport.sv
module i2c_gated_regport #(
  parameter logic [6:0] DEV_ADDR = 7'h10,
  parameter logic [6:0] UNL_ADDR = 7'h11,
  parameter logic [7:0] UNL_PTR  = 8'h81,
  parameter logic [7:0] KEY_A    = 8'hF4,
  parameter logic [7:0] KEY_B    = 8'h4F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK} st_t;

  st_t        st;
  logic [2:0] scl_q, sda_q;
  logic [3:0] bitcnt;
  logic [2:0] byte_idx;
  logic [7:0] sh, txsh;
  logic [6:0] ptr;
  logic       blk, rw, sel_unl, key_ok, unlocked, mack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl     = scl_q[1];
  wire scl_d   = scl_q[2];
  wire sda     = sda_q[1];
  wire sda_d   = sda_q[2];
  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c  = scl & scl_d & ~sda_d & sda;
  wire rise    = scl & ~scl_d;
  wire fall    = ~scl & scl_d;

  wire byte_done = (st == S_RX) && fall && (bitcnt == 4'd8);
  wire hit_main  = (sh[7:1] == DEV_ADDR) && unlocked;
  wire hit_unl   = (sh == {UNL_ADDR, 1'b0});
  wire wr_fire   = byte_done && (byte_idx >= 3'd2) && !sel_unl &&
                   (blk || byte_idx == 3'd2);

  assign reg_we    = wr_fire;
  assign reg_addr  = ptr;
  assign reg_wdata = sh;
  assign sda_oe    = (st == S_ACK) || ((st == S_TX) && !txsh[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      bitcnt   <= '0;
      byte_idx <= '0;
      sh       <= '0;
      txsh     <= '0;
      ptr      <= '0;
      blk      <= 1'b0;
      rw       <= 1'b0;
      sel_unl  <= 1'b0;
      key_ok   <= 1'b0;
      unlocked <= 1'b0;
      mack     <= 1'b0;
    end else if (start_c) begin
      st       <= S_RX;
      bitcnt   <= '0;
      byte_idx <= '0;
      sel_unl  <= 1'b0;
      key_ok   <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      if (sel_unl && key_ok && byte_idx == 3'd4) unlocked <= 1'b1;
      sel_unl <= 1'b0;
      key_ok  <= 1'b0;
    end else begin
      case (st)
        S_RX: begin
          if (rise && bitcnt < 4'd8) begin
            sh     <= {sh[6:0], sda};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            bitcnt <= '0;
            if (byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
            if (byte_idx == 3'd0) begin
              if (hit_main) begin
                st      <= S_ACK;
                rw      <= sh[0];
                sel_unl <= 1'b0;
              end else if (hit_unl) begin
                st      <= S_ACK;
                rw      <= 1'b0;
                sel_unl <= 1'b1;
                key_ok  <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st <= S_ACK;
              if (sel_unl) begin
                case (byte_idx)
                  3'd1:    if (sh != UNL_PTR) key_ok <= 1'b0;
                  3'd2:    if (sh != KEY_A)   key_ok <= 1'b0;
                  3'd3:    if (sh != KEY_B)   key_ok <= 1'b0;
                  default: key_ok <= 1'b0;
                endcase
              end else if (byte_idx == 3'd1) begin
                blk <= sh[7];
                ptr <= sh[6:0];
              end else if (wr_fire && blk) begin
                ptr <= ptr + 7'd1;
              end
            end
          end
        end
        S_ACK:
          if (fall) begin
            bitcnt <= '0;
            if (rw) begin
              st   <= S_TX;
              txsh <= reg_rdata;
            end else begin
              st <= S_RX;
            end
          end
        S_TX:
          if (fall) begin
            if (bitcnt == 4'd7) begin
              st <= S_RACK;
              if (blk) ptr <= ptr + 7'd1;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        S_RACK: begin
          if (rise) mack <= ~sda;
          if (fall) begin
            bitcnt <= '0;
            if (mack) begin
              st   <= S_TX;
              txsh <= reg_rdata;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_q[1]));

  // R2
  no_we_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> unlocked);

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);

  // R8
  blk_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && blk) |=> (reg_addr == $past(reg_addr) + 7'd1));

  // R6
  sgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !blk) |=> (reg_addr == $past(reg_addr)));

  // R10
  nack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_RACK) && fall && !mack && !start_c && !stop_c) |=> !sda_oe);

endmodule

// File: tb/i2c_gated_regport_tb.sv
module i2c_gated_regport_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [128];
  wire sda_line = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0, we_cnt = 0, oe_cnt = 0, viol = 0;
  bit done = 0;
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  i2c_gated_regport dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end
  always @(negedge clk) begin
    if (scl_m && prev_scl && (sda_oe != prev_oe)) viol <= viol + 1;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  localparam logic [15:0] VEC [8] = '{
    {8'h00, 8'h5A}, {8'h05, 8'hA5}, {8'h12, 8'h3C}, {8'h40, 8'hC3},
    {8'h55, 8'h01}, {8'h6A, 8'hFE}, {8'h7F, 8'h80}, {8'h3C, 8'h77}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic i_start();
    sda_m = 1; scl_m = 1; wq(1); sda_m = 0; wq(2); scl_m = 0;
  endtask
  task automatic i_rstart();
    wq(1); sda_m = 1; wq(1); scl_m = 1; wq(2); sda_m = 0; wq(2); scl_m = 0;
  endtask
  task automatic i_stop();
    wq(1); sda_m = 0; wq(1); scl_m = 1; wq(2); sda_m = 1; wq(2);
  endtask
  task automatic i_bit(input logic b);
    wq(1); sda_m = b; wq(1); scl_m = 1; wq(2); scl_m = 0;
  endtask
  task automatic wbyte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) i_bit(b[i]);
    wq(1); sda_m = 1; wq(1); scl_m = 1; wq(1); a = sda_line; wq(1); scl_m = 0;
  endtask
  task automatic rbyte(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      wq(1); sda_m = 1; wq(1); scl_m = 1; wq(1); d[i] = sda_line; wq(1); scl_m = 0;
    end
    wq(1); sda_m = ~ack; wq(1); scl_m = 1; wq(2); scl_m = 0; wq(1); sda_m = 1;
  endtask
  task automatic wr_seq(input int n, input logic [39:0] bs, output logic [4:0] acks);
    logic a;
    acks = '1;
    i_start();
    for (int i = 0; i < n; i++) begin
      wbyte(bs[39-8*i -: 8], a);
      acks[i] = a;
    end
    i_stop();
  endtask
  task automatic probe(output logic a);
    i_start(); wbyte(8'h20, a); i_stop();
  endtask
  task automatic sgl_read(input logic [6:0] p, output logic [7:0] d);
    logic a;
    i_start(); wbyte(8'h20, a); wbyte({1'b0, p}, a);
    i_rstart(); wbyte(8'h21, a); rbyte(1'b0, d); i_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [4:0] acks;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 128; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 reg_we after reset", reg_we, 0);

    wr_seq(3, {8'h20, 8'h05, 8'h99, 16'h0}, acks);
    chk("R2 locked write addr nack", acks[0], 1);
    i_start(); wbyte(8'h21, a); i_stop();
    chk("R2 locked read addr nack", a, 1);
    chk("R2 no writes while locked", we_cnt, 0);

    i_start(); wbyte(8'h50, a); i_stop();
    chk("R5 foreign addr nack", a, 1);
    i_start(); wbyte(8'h23, a); i_stop();
    chk("R5 unlock addr read nack", a, 1);

    wr_seq(4, {8'h22, 8'h81, 8'hF4, 8'h4E, 8'h00}, acks);
    probe(a); chk("R4 wrong key stays locked", a, 1);
    wr_seq(3, {8'h22, 8'h81, 8'hF4, 16'h0}, acks);
    probe(a); chk("R4 early stop stays locked", a, 1);
    wr_seq(5, {8'h22, 8'h81, 8'hF4, 8'h4F, 8'h00}, acks);
    probe(a); chk("R4 extra byte stays locked", a, 1);
    wr_seq(4, {8'h22, 8'h01, 8'hF4, 8'h4F, 8'h00}, acks);
    probe(a); chk("R4 wrong pointer stays locked", a, 1);
    i_start(); wbyte(8'h22, a); wbyte(8'h81, a); wbyte(8'hF4, a);
    i_rstart(); wbyte(8'h4F, a); i_stop();
    probe(a); chk("R4 repeated start stays locked", a, 1);
    chk("R2 still no writes", we_cnt, 0);

    wr_seq(4, {8'h22, 8'h81, 8'hF4, 8'h4F, 8'h00}, acks);
    chk("R3 unlock bytes acked", acks[3:0], 0);
    probe(a); chk("R3 address acked after unlock", a, 0);

    for (int i = 0; i < 8; i++) begin
      wr_seq(3, {8'h20, VEC[i][15:8], VEC[i][7:0], 16'h0}, acks);
      chk("R11 write acks", acks[2:0], 0);
      sgl_read(VEC[i][14:8], d);
      chk("R7 single readback", d, VEC[i][7:0]);
    end

    w0 = we_cnt;
    wr_seq(4, {8'h20, 8'h30, 8'hAA, 8'hBB, 8'h00}, acks);
    chk("R6 extra byte acked", acks[3], 0);
    chk("R6 one strobe", we_cnt - w0, 1);
    sgl_read(7'h30, d); chk("R6 first byte stored", d, 8'hAA);
    sgl_read(7'h31, d); chk("R6 next addr untouched", d, 8'h00);

    wr_seq(5, {8'h20, 8'hFE, 8'h11, 8'h22, 8'h33}, acks);
    sgl_read(7'h7E, d); chk("R8 block byte 0", d, 8'h11);
    sgl_read(7'h7F, d); chk("R8 block byte 1", d, 8'h22);
    sgl_read(7'h00, d); chk("R8 block wrap", d, 8'h33);

    i_start(); wbyte(8'h20, a); wbyte(8'hFE, a);
    i_rstart(); wbyte(8'h21, a);
    rbyte(1'b1, d); chk("R9 block read 0", d, 8'h11);
    rbyte(1'b1, d); chk("R9 block read 1", d, 8'h22);
    rbyte(1'b0, d); chk("R9 block read wrap", d, 8'h33);
    w0 = oe_cnt;
    rbyte(1'b0, d);
    chk("R10 released after nack", d, 8'hFF);
    chk("R10 no drive after nack", oe_cnt - w0, 0);
    i_stop();

    w0 = we_cnt;
    i_start(); wbyte(8'h20, a); wbyte(8'h40, a);
    i_bit(1'b1); i_bit(1'b0); i_bit(1'b1);
    i_rstart(); wbyte(8'h21, a);
    chk("R12 address phase after restart", a, 0);
    rbyte(1'b0, d); i_stop();
    chk("R12 read after restart", d, 8'hC3);
    chk("R12 partial byte not written", we_cnt - w0, 0);

    chk("R11 oe stable while scl high", viol, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule